// File: doc/BRIEF.md
# Embedded-Sync Component Video Word Decoder

This block takes a byte-serial 4:2:2 component video stream, one word per clock when the valid input is high. Words are 8 bits wide by default, or 10 bits when the width parameter is set to 10. It recovers all timing from the stream itself. A fixed three-word preamble (all ones, all zeros, all zeros) announces a control word. The decoder checks that word against its parity protection bits. From a good word it takes the field, vertical-blanking and horizontal-blanking flags.

Between a start-of-active-video code and the next all-ones word, the block counts incoming words in the order Cb, Y, Cr, Y. It delivers pixels as {Y, Cb, Cr}, and each pixel pair shares one chroma pair. It also gives a line-start pulse, a field-start pulse and an error pulse for corrupted control words. All outputs are registered and change on the clock edge that accepts the causing word.

Top module: `vid656_decoder`

## Requirements
- R1: A word is decoded as a control word only when it directly follows an all-ones, all-zeros, all-zeros sequence of valid words. A repeated all-ones word restarts the sequence. Any other word breaks it.
- R2: In a control word laid out [7]=1, [6]=F, [5]=V, [4]=H, [3]=V^H, [2]=F^H, [1]=F^V, [0]=F^V^H, a wrong protection bit or a zero MSB raises codeErr for one cycle. The flags and sampling state are then left unchanged.
- R3: A good control word loads fieldFlag=F, vBlank=V and hBlank=H, visible one cycle after the word.
- R4: After reset, fieldFlag=0, vBlank=1 and hBlank=1, and all pulses and pixValid are low.
- R5: A good control word with H=0 and V=0 pulses lineStart for one cycle. It also restarts the sample phase at Cb.
- R6: fieldStart pulses, together with lineStart, on code 8'h80 or 8'hC7 (10-bit 10'h200 or 10'h31C). It does so only when the previous good code had V=1 or a different F. fieldFlag then carries the new field.
- R7: Active words arrive as Cb, Y0, Cr, Y1. On the Cr word, pixel {Y0, Cb, Cr} is output. On the Y1 word, pixel {Y1, Cb, Cr} is output with the same chroma. pixValid is high in those cycles only.
- R8: Samples are taken only after a start-of-active-video code. An all-ones word, or any good code other than start-of-active-video, stops sampling until the next such code.
- R9: With 10-bit words, the control word sits in the upper 8 bits and its two LSBs must be zero, otherwise codeErr is raised. The preamble is 10'h3FF, 10'h000, 10'h000.
- R10: A word presented with inValid low is ignored by the preamble search, the sample phase and all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inWord | input | WORD_W | Stream word |
| inValid | input | 1 | Word qualifier |
| pixY | output | WORD_W | Pixel luma |
| pixCb | output | WORD_W | Pixel blue-difference chroma |
| pixCr | output | WORD_W | Pixel red-difference chroma |
| pixValid | output | 1 | Pixel strobe |
| lineStart | output | 1 | Start of active line pulse |
| fieldStart | output | 1 | First active line of a field pulse |
| fieldFlag | output | 1 | Current field (0 first, 1 second) |
| vBlank | output | 1 | Vertical blanking flag |
| hBlank | output | 1 | Horizontal blanking flag |
| codeErr | output | 1 | Protection failure pulse |

## Verification
The stream patterns cover several cases:
- Clean lines in both fields, which separate correct chroma pairing from swapped or stale chroma.
- A line cut off mid-pair, and blank-region data after a vertical-blanking start code, which show whether sampling stops when it should.
- A code with one flipped protection bit, a broken preamble, a doubled all-ones word, and an idle word inside the preamble, which tell a real code from data that resembles one.
- A second instance in 10-bit mode, which runs a code with non-zero padding bits against the same codes with correct padding.

// File: rtl/vid656_pkg.sv
package vid656_pkg;

  typedef enum logic [1:0] {
    PRE_HUNT  = 2'd0,
    PRE_ONES  = 2'd1,
    PRE_ZERO1 = 2'd2,
    PRE_ZERO2 = 2'd3
  } preState_e;

  // Strobes from control to datapath; at most one is high per cycle.
  typedef struct packed {
    logic takeCb;
    logic takeY0;
    logic emitP0;
    logic emitP1;
  } smpStb_t;

  // Protection check over the 8 significant control bits.
  function automatic logic protOk(input logic [7:0] c);
    logic f, v, h;
    f = c[6];
    v = c[5];
    h = c[4];
    return c[7] && (c[3] == (v ^ h)) && (c[2] == (f ^ h)) &&
           (c[1] == (f ^ v)) && (c[0] == (f ^ v ^ h));
  endfunction

endpackage

// File: rtl/vid656_ctrl.sv
module vid656_ctrl
  import vid656_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] inWord,
  input  logic              inValid,
  output smpStb_t           stb,
  output logic              lineStart,
  output logic              fieldStart,
  output logic              fieldFlag,
  output logic              vBlank,
  output logic              hBlank,
  output logic              codeErr
);

  localparam int PH_W = 2;
  localparam logic [WORD_W-1:0] ALL_ONES = {WORD_W{1'b1}};
  localparam logic [WORD_W-1:0] ALL_ZERO = '0;

  preState_e preQ, preD;
  logic [PH_W-1:0] phaseQ;
  logic activeQ;
  logic [7:0] codeByte;
  logic padOk, codeNow, codeGood, codeBad, isSav, fsNow, sampleNow, isOnes;

  assign codeByte = inWord[WORD_W-1 -: 8];

  generate
    if (WORD_W > 8) begin : g_pad
      assign padOk = (inWord[WORD_W-9:0] == '0);
    end else begin : g_nopad
      assign padOk = 1'b1;
    end
  endgenerate

  assign isOnes    = (inWord == ALL_ONES);
  assign codeNow   = inValid && (preQ == PRE_ZERO2);
  assign codeGood  = codeNow && padOk && protOk(codeByte);
  assign codeBad   = codeNow && !codeGood;
  assign isSav     = codeGood && !codeByte[4] && !codeByte[5];
  assign fsNow     = isSav && ((codeByte == 8'h80) || (codeByte == 8'hC7)) &&
                     (vBlank || (fieldFlag != codeByte[6]));
  assign sampleNow = inValid && activeQ && (preQ == PRE_HUNT) && !isOnes;

  always_comb begin
    preD = preQ;
    if (inValid) begin
      unique case (preQ)
        PRE_HUNT:  preD = isOnes ? PRE_ONES : PRE_HUNT;
        PRE_ONES:  preD = isOnes ? PRE_ONES :
                          (inWord == ALL_ZERO) ? PRE_ZERO1 : PRE_HUNT;
        PRE_ZERO1: preD = isOnes ? PRE_ONES :
                          (inWord == ALL_ZERO) ? PRE_ZERO2 : PRE_HUNT;
        PRE_ZERO2: preD = PRE_HUNT;
        default:   preD = PRE_HUNT;
      endcase
    end
  end

  always_comb begin
    stb = '0;
    if (sampleNow) begin
      unique case (phaseQ)
        2'd0:    stb.takeCb = 1'b1;
        2'd1:    stb.takeY0 = 1'b1;
        2'd2:    stb.emitP0 = 1'b1;
        default: stb.emitP1 = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      preQ       <= PRE_HUNT;
      phaseQ     <= '0;
      activeQ    <= 1'b0;
      fieldFlag  <= 1'b0;
      vBlank     <= 1'b1;
      hBlank     <= 1'b1;
      lineStart  <= 1'b0;
      fieldStart <= 1'b0;
      codeErr    <= 1'b0;
    end else begin
      preQ       <= preD;
      lineStart  <= isSav;
      fieldStart <= fsNow;
      codeErr    <= codeBad;
      if (codeGood) begin
        fieldFlag <= codeByte[6];
        vBlank    <= codeByte[5];
        hBlank    <= codeByte[4];
      end
      if (isSav) begin
        activeQ <= 1'b1;
        phaseQ  <= '0;
      end else if (codeGood || (inValid && isOnes)) begin
        activeQ <= 1'b0;
      end else if (sampleNow) begin
        phaseQ <= phaseQ + 1'b1;
      end
    end
  end

  // R2: a rejected control word leaves the flags where they were
  p_err_holds_flags_r2: assert property (@(posedge clk) disable iff (!rst_n)
    codeErr |-> $stable({fieldFlag, vBlank, hBlank}));

  // R5: a line start always follows an accepted active-video code
  p_line_clears_blank_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lineStart |-> (!vBlank && !hBlank && !codeErr));

  // R6: a field start is always also a line start
  p_field_with_line_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fieldStart |-> lineStart);

  // R7: strobes to the datapath are mutually exclusive
  p_stb_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(stb));

endmodule

// File: rtl/vid656_dpath.sv
module vid656_dpath
  import vid656_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  smpStb_t           stb,
  input  logic [WORD_W-1:0] inWord,
  output logic [WORD_W-1:0] pixY,
  output logic [WORD_W-1:0] pixCb,
  output logic [WORD_W-1:0] pixCr,
  output logic              pixValid
);

  logic [WORD_W-1:0] cbHold, y0Hold, crHold;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cbHold   <= '0;
      y0Hold   <= '0;
      crHold   <= '0;
      pixY     <= '0;
      pixCb    <= '0;
      pixCr    <= '0;
      pixValid <= 1'b0;
    end else begin
      pixValid <= stb.emitP0 || stb.emitP1;
      if (stb.takeCb) cbHold <= inWord;
      if (stb.takeY0) y0Hold <= inWord;
      if (stb.emitP0) begin
        crHold <= inWord;
        pixY   <= y0Hold;
        pixCb  <= cbHold;
        pixCr  <= inWord;
      end
      if (stb.emitP1) begin
        pixY  <= inWord;
        pixCb <= cbHold;
        pixCr <= crHold;
      end
    end
  end

  // R7: the second pixel of a pair reuses the chroma of the first
  p_pair_chroma_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stb.emitP1 |=> (pixValid && $stable(crHold)));

endmodule

// File: rtl/vid656_decoder.sv
module vid656_decoder
  import vid656_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] inWord,
  input  logic              inValid,
  output logic [WORD_W-1:0] pixY,
  output logic [WORD_W-1:0] pixCb,
  output logic [WORD_W-1:0] pixCr,
  output logic              pixValid,
  output logic              lineStart,
  output logic              fieldStart,
  output logic              fieldFlag,
  output logic              vBlank,
  output logic              hBlank,
  output logic              codeErr
);

  smpStb_t stb;

  vid656_ctrl #(.WORD_W(WORD_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .inWord(inWord), .inValid(inValid), .stb(stb),
    .lineStart(lineStart), .fieldStart(fieldStart), .fieldFlag(fieldFlag),
    .vBlank(vBlank), .hBlank(hBlank), .codeErr(codeErr)
  );

  vid656_dpath #(.WORD_W(WORD_W)) u_dpath (
    .clk(clk), .rst_n(rst_n), .stb(stb), .inWord(inWord),
    .pixY(pixY), .pixCb(pixCb), .pixCr(pixCr), .pixValid(pixValid)
  );

  // R8: pixels appear only while the flags say active video
  p_pix_in_active_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pixValid |-> (!vBlank && !hBlank));

endmodule

// File: tb/tb_vid656_decoder.sv
`timescale 1ns/1ps
module tb_vid656_decoder;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [7:0] w8;
  logic       v8;
  logic [7:0] y8, cb8, cr8;
  logic       pv8, ln8, fs8, ff8, vb8, hb8, er8;

  logic [9:0] w10;
  logic       v10;
  logic [9:0] y10, cb10, cr10;
  logic       pv10, ln10, fs10, ff10, vb10, hb10, er10;

  vid656_decoder #(.WORD_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .inWord(w8), .inValid(v8),
    .pixY(y8), .pixCb(cb8), .pixCr(cr8), .pixValid(pv8),
    .lineStart(ln8), .fieldStart(fs8), .fieldFlag(ff8),
    .vBlank(vb8), .hBlank(hb8), .codeErr(er8)
  );

  vid656_decoder #(.WORD_W(10)) dut10 (
    .clk(clk), .rst_n(rst_n), .inWord(w10), .inValid(v10),
    .pixY(y10), .pixCb(cb10), .pixCr(cr10), .pixValid(pv10),
    .lineStart(ln10), .fieldStart(fs10), .fieldFlag(ff10),
    .vBlank(vb10), .hBlank(hb10), .codeErr(er10)
  );

  int total = 0;
  int bad = 0;

  typedef struct packed {
    bit       vld;
    bit [7:0] w;
    bit       pix;
    bit [7:0] y;
    bit [7:0] cb;
    bit [7:0] cr;
    bit       ln;
    bit       fs;
    bit       er;
    bit       f;
    bit       v;
    bit       h;
  } vec_t;

  localparam int N = 61;
  // Expected values are those visible one cycle after the word is accepted.
  localparam vec_t VECS [0:N-1] = '{
    '{1,8'hFF,0,0,0,0,0,0,0,0,1,1}, '{1,8'h00,0,0,0,0,0,0,0,0,1,1},
    '{1,8'h00,0,0,0,0,0,0,0,0,1,1}, '{1,8'hB6,0,0,0,0,0,0,0,0,1,1},
    '{1,8'h10,0,0,0,0,0,0,0,0,1,1}, // blank data: no pixel (R8)
    '{1,8'hFF,0,0,0,0,0,0,0,0,1,1}, '{1,8'h00,0,0,0,0,0,0,0,0,1,1},
    '{1,8'h00,0,0,0,0,0,0,0,0,1,1},
    '{1,8'h80,0,0,0,0,1,1,0,0,0,0}, // first active line of field 0
    '{1,8'h40,0,0,0,0,0,0,0,0,0,0}, '{1,8'h51,0,0,0,0,0,0,0,0,0,0},
    '{1,8'h62,1,8'h51,8'h40,8'h62,0,0,0,0,0,0},
    '{1,8'h73,1,8'h73,8'h40,8'h62,0,0,0,0,0,0},
    '{1,8'h44,0,0,0,0,0,0,0,0,0,0}, '{1,8'h55,0,0,0,0,0,0,0,0,0,0},
    '{1,8'h66,1,8'h55,8'h44,8'h66,0,0,0,0,0,0},
    '{1,8'h77,1,8'h77,8'h44,8'h66,0,0,0,0,0,0},
    '{1,8'hFF,0,0,0,0,0,0,0,0,0,0}, '{1,8'h00,0,0,0,0,0,0,0,0,0,0},
    '{1,8'h00,0,0,0,0,0,0,0,0,0,0},
    '{1,8'h9D,0,0,0,0,0,0,0,0,0,1}, // end of active video
    '{1,8'hFF,0,0,0,0,0,0,0,0,0,1}, '{1,8'h00,0,0,0,0,0,0,0,0,0,1},
    '{1,8'h00,0,0,0,0,0,0,0,0,0,1},
    '{1,8'h80,0,0,0,0,1,0,0,0,0,0}, // second line: no field start
    '{1,8'h20,0,0,0,0,0,0,0,0,0,0}, '{1,8'h30,0,0,0,0,0,0,0,0,0,0},
    '{1,8'hFF,0,0,0,0,0,0,0,0,0,0}, // cut mid-pair: no pixel (R8)
    '{1,8'h00,0,0,0,0,0,0,0,0,0,0}, '{1,8'h00,0,0,0,0,0,0,0,0,0,0},
    '{1,8'h81,0,0,0,0,0,0,1,0,0,0}, // bad protection bit
    '{1,8'h21,0,0,0,0,0,0,0,0,0,0},
    '{1,8'hFF,0,0,0,0,0,0,0,0,0,0}, '{1,8'h00,0,0,0,0,0,0,0,0,0,0},
    '{1,8'h00,0,0,0,0,0,0,0,0,0,0},
    '{1,8'hC7,0,0,0,0,1,1,0,1,0,0}, // field change
    '{0,8'h11,0,0,0,0,0,0,0,1,0,0}, // idle word (R10)
    '{1,8'h12,0,0,0,0,0,0,0,1,0,0}, '{1,8'h13,0,0,0,0,0,0,0,1,0,0},
    '{1,8'h14,1,8'h13,8'h12,8'h14,0,0,0,1,0,0},
    '{0,8'h00,0,0,0,0,0,0,0,1,0,0}, // idle word (R10)
    '{1,8'h15,1,8'h15,8'h12,8'h14,0,0,0,1,0,0},
    '{1,8'hFF,0,0,0,0,0,0,0,1,0,0}, '{1,8'h00,0,0,0,0,0,0,0,1,0,0},
    '{1,8'h00,0,0,0,0,0,0,0,1,0,0},
    '{1,8'hEC,0,0,0,0,0,0,0,1,1,0}, // active code in vertical blanking
    '{1,8'h25,0,0,0,0,0,0,0,1,1,0}, // not sampled (R8)
    '{1,8'hFF,0,0,0,0,0,0,0,1,1,0}, '{1,8'h00,0,0,0,0,0,0,0,1,1,0},
    '{1,8'h05,0,0,0,0,0,0,0,1,1,0}, // broken preamble (R1)
    '{1,8'hB6,0,0,0,0,0,0,0,1,1,0}, // taken as data, flags kept (R1)
    '{1,8'hFF,0,0,0,0,0,0,0,1,1,0},
    '{0,8'h55,0,0,0,0,0,0,0,1,1,0}, // idle inside preamble (R10)
    '{1,8'h00,0,0,0,0,0,0,0,1,1,0}, '{1,8'h00,0,0,0,0,0,0,0,1,1,0},
    '{1,8'h9D,0,0,0,0,0,0,0,0,0,1},
    '{1,8'hFF,0,0,0,0,0,0,0,0,0,1}, '{1,8'hFF,0,0,0,0,0,0,0,0,0,1},
    '{1,8'h00,0,0,0,0,0,0,0,0,0,1}, '{1,8'h00,0,0,0,0,0,0,0,0,0,1},
    '{1,8'hDA,0,0,0,0,0,0,0,1,0,1}  // doubled all-ones still frames (R1)
  };

  task automatic chk(input string tag, input int step, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s step %0d: actual=%0h expected=%0h", tag, step, act, exp);
    end
  endtask

  task automatic put10(input logic [9:0] word);
    w10 = word;
    v10 = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    w8 = '0; v8 = 1'b0; w10 = '0; v10 = 1'b0;
    repeat (3) @(negedge clk);
    // R4: reset state
    chk("R4 flags", -1, {ff8, vb8, hb8}, 3'b011);
    chk("R4 pulses", -1, {pv8, ln8, fs8, er8}, 4'b0000);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < N; i++) begin
      w8 = VECS[i].w;
      v8 = VECS[i].vld;
      @(negedge clk);
      chk("R3 flags (R1 framing)", i, {ff8, vb8, hb8},
          {VECS[i].f, VECS[i].v, VECS[i].h});
      chk("R7 R8 pixel strobe", i, pv8, VECS[i].pix);
      if (VECS[i].pix)
        chk("R7 pixel value", i, {y8, cb8, cr8},
            {VECS[i].y, VECS[i].cb, VECS[i].cr});
      chk("R5 line start", i, ln8, VECS[i].ln);
      chk("R6 field start", i, fs8, VECS[i].fs);
      chk("R2 code error", i, er8, VECS[i].er);
    end
    v8 = 1'b0;

    // R9: 10-bit words
    put10(10'h3FF); put10(10'h000); put10(10'h000); put10(10'h200);
    chk("R9 10b start", 100, {ln10, fs10, ff10, vb10, hb10}, 5'b11000);
    put10(10'h3FF); put10(10'h000); put10(10'h000); put10(10'h31D);
    chk("R9 10b pad err", 101, {er10, ln10, ff10, vb10, hb10}, 5'b10000);
    put10(10'h3FF); put10(10'h000); put10(10'h000); put10(10'h31C);
    chk("R9 10b field 1", 102, {ln10, fs10, ff10, er10}, 4'b1110);
    put10(10'h100); put10(10'h104); put10(10'h108);
    chk("R9 10b pixel", 103, {pv10, y10, cb10, cr10},
        {1'b1, 10'h104, 10'h100, 10'h108});
    v10 = 1'b0;
    @(negedge clk);

    // R4: reset in mid-run restores the flags
    rst_n = 1'b0;
    @(negedge clk);
    chk("R4 re-reset flags", 104, {ff10, vb10, hb10, ff8, vb8, hb8}, 6'b011011);
    chk("R4 re-reset pix", 105, {pv8, pv10, ln8, ln10}, 4'b0000);
    rst_n = 1'b1;
    @(negedge clk);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule